// File: doc/BRIEF.md
# UART Baud Rate Generator with Receive Majority Filter

This block turns the system clock into a single-cycle bit-rate tick for a serial port. The tick period is set by a divisor register and three mode inputs: counter width, speed, and synchronous versus asynchronous operation. Internally, a fixed prescaler of 64, 16 or 4 clocks feeds a down-counter that reloads from the divisor. Together they divide the clock by the prescale length times (divisor + 1).

A write to the divisor, or any change on a mode input, restarts both counters at once. The new rate therefore applies without waiting for the old period to end. In synchronous operation, effective divisors below 2 are unsupported; the block raises a configuration error and holds the tick low.

The block also includes a three-sample majority filter for the receive line. It samples the line at three adjacent prescaler phases around the middle of the bit. The filter then presents the voted level with a one-cycle valid strobe.

Top module: `baud_rate_gen`

## Requirements
- R1: After reset the divisor holds 0 and the block behaves as asynchronous, 8-bit, low speed. `cfg_err_o` and `tick_o` are low, and the first tick arrives on the 64th rising edge after reset release.
- R2: Asynchronous, 8-bit (`wide_i`=0), low speed (`fast_i`=0): the tick period is 64 x (n+1) clocks. Here n is bits [7:0] of the divisor, and bits [15:8] have no effect.
- R3: Asynchronous with exactly one of `wide_i` and `fast_i` set: the tick period is 16 x (n+1). n is the full 16-bit divisor when `wide_i`=1 and bits [7:0] otherwise.
- R4: Asynchronous with both `wide_i` and `fast_i` set: the tick period is 4 x (n+1), with n the full 16-bit divisor.
- R5: Synchronous (`sync_i`=1): the tick period is 4 x (n+1) for both widths, and `fast_i` has no effect. n follows `wide_i` as in R3.
- R6: A divisor write restarts the division. The first tick comes exactly one full new period after the clock edge that takes the write, and no tick is issued on the cycle after a write.
- R7: `cfg_err_o` is high whenever `sync_i`=1 and the effective n is 0 or 1, and no tick is issued while it is high. In asynchronous mode every divisor value is legal and `cfg_err_o` stays low.
- R8: `tick_o` is never high on two consecutive cycles.
- R9: The receive line is sampled at prescaler phases P/2-1, P/2 and P/2+1, where P is the prescale length. Sampling happens only during the prescaler pass in which the down-counter equals floor(n/2). On the cycle after the third sample, `rx_bit_o` shows the majority of the three samples and `rx_valid_o` is high for one cycle.
- R10: A change on any of `sync_i`, `wide_i` or `fast_i` restarts the division just as a divisor write does. The next tick comes one full new period after the edge that sees the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| div_wdata | input | 16 | Divisor value to store |
| div_we | input | 1 | Divisor write strobe |
| wide_i | input | 1 | 1: full 16-bit divisor, 0: low byte only |
| fast_i | input | 1 | High-speed select (asynchronous mode only) |
| sync_i | input | 1 | 1: synchronous mode, 0: asynchronous mode |
| rx_i | input | 1 | Receive line to be filtered |
| tick_o | output | 1 | One-cycle bit-rate tick |
| cfg_err_o | output | 1 | Unsupported synchronous divisor |
| rx_bit_o | output | 1 | Majority-voted receive level |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_bit_o` |

## Verification
The assertions check the following on every cycle:
- the tick and the filter strobe are single-cycle pulses;
- no tick follows a divisor write;
- an error that persists blocks the tick;
- asynchronous settings never flag an error.

The exact division ratio for each combination of width, speed and mode, the ignored high byte and speed bit, restart latency after a write or a mode change, and the voted level for each sample pattern are shown only by the bench's scenarios. The bench checks them by counting cycles between edges and ticks.

// File: rtl/baud_pkg.sv
package baud_pkg;

  typedef enum logic [1:0] {
    RATE_SLOW = 2'd0,
    RATE_MID  = 2'd1,
    RATE_FAST = 2'd2
  } rate_e;

  // Prescale class from the mode inputs; synchronous ignores the speed bit.
  function automatic rate_e pick_rate(input logic sync_m, input logic wide_m,
                                      input logic fast_m);
    rate_e r;
    if (sync_m) begin
      r = RATE_FAST;
    end else begin
      unique case ({wide_m, fast_m})
        2'b00:   r = RATE_SLOW;
        2'b11:   r = RATE_FAST;
        default: r = RATE_MID;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PRE_W-1:0] last,
  output logic [PRE_W-1:0] phase,
  output logic             wrap
);

  logic [PRE_W-1:0] phase_d;

  assign wrap = (phase >= last);

  always_comb begin
    if (restart)   phase_d = '0;
    else if (wrap) phase_d = '0;
    else           phase_d = phase + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase_d;
  end

endmodule

// File: rtl/baud_down_counter.sv
module baud_down_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             at_zero
);

  logic [CNT_W-1:0] count_d;
  logic             count_en;

  assign at_zero  = (count == '0);
  assign count_en = restart | step;

  always_comb begin
    if (restart)      count_d = load_val;
    else if (at_zero) count_d = reload_val;
    else              count_d = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (count_en) count <= count_d;
  end

endmodule

// File: rtl/baud_rx_vote.sv
module baud_rx_vote (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  input  logic cap_first,
  input  logic cap_second,
  input  logic cap_third,
  output logic bit_o,
  output logic valid_o
);

  logic s_first, s_second;
  logic s_first_d, s_second_d;
  logic bit_d, valid_d;
  logic vote;

  assign vote = (s_first & s_second) | (s_first & rx_i) | (s_second & rx_i);

  always_comb begin
    s_first_d  = cap_first  ? rx_i : s_first;
    s_second_d = cap_second ? rx_i : s_second;
    bit_d      = cap_third  ? vote : bit_o;
    valid_d    = cap_third;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_first  <= 1'b1;
      s_second <= 1'b1;
      bit_o    <= 1'b1;
      valid_o  <= 1'b0;
    end else begin
      s_first  <= s_first_d;
      s_second <= s_second_d;
      bit_o    <= bit_d;
      valid_o  <= valid_d;
    end
  end

endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen
  import baud_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int LOW_W    = 8,
  parameter int PRE_SLOW = 64,
  parameter int PRE_MID  = 16,
  parameter int PRE_FAST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             div_we,
  input  logic             wide_i,
  input  logic             fast_i,
  input  logic             sync_i,
  input  logic             rx_i,
  output logic             tick_o,
  output logic             cfg_err_o,
  output logic             rx_bit_o,
  output logic             rx_valid_o
);

  localparam int PRE_W = $clog2(PRE_SLOW);

  // Stored divisor and mode history
  logic [DIV_W-1:0] div_q, div_d;
  logic [2:0]       mode_q, mode_now;
  logic             mode_chg;
  logic             restart;

  // Effective divisor: full word or low byte only
  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] src,
                                               input logic wide_m);
    logic [DIV_W-1:0] r;
    r = src;
    if (!wide_m) r[DIV_W-1:LOW_W] = '0;
    return r;
  endfunction

  logic [DIV_W-1:0] n_cur, n_load;
  rate_e            rate;
  logic [PRE_W-1:0] pre_last, pre_half;
  logic [PRE_W-1:0] phase;
  logic             pre_wrap;
  logic [DIV_W-1:0] cnt;
  logic             cnt_zero;
  logic             tick_d;
  logic             mid_hit;
  logic             cap0, cap1, cap2;

  assign mode_now = {sync_i, wide_i, fast_i};
  assign mode_chg = (mode_now != mode_q);
  assign restart  = div_we | mode_chg;

  assign div_d  = div_we ? div_wdata : div_q;
  assign n_cur  = eff_div(div_q, wide_i);
  assign n_load = eff_div(div_d, wide_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      mode_q <= '0;
    end else begin
      div_q  <= div_d;
      mode_q <= mode_now;
    end
  end

  // Prescale length from the mode
  assign rate = pick_rate(sync_i, wide_i, fast_i);

  always_comb begin
    unique case (rate)
      RATE_SLOW: pre_last = PRE_W'(PRE_SLOW - 1);
      RATE_MID:  pre_last = PRE_W'(PRE_MID - 1);
      default:   pre_last = PRE_W'(PRE_FAST - 1);
    endcase
  end

  assign pre_half = (pre_last >> 1) + 1'b1;

  // Unsupported synchronous setting
  assign cfg_err_o = sync_i & (n_cur < DIV_W'(2));

  baud_prescaler #(.PRE_W(PRE_W)) i_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .last    (pre_last),
    .phase   (phase),
    .wrap    (pre_wrap)
  );

  baud_down_counter #(.CNT_W(DIV_W)) i_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .step       (pre_wrap),
    .load_val   (n_load),
    .reload_val (n_cur),
    .count      (cnt),
    .at_zero    (cnt_zero)
  );

  // Tick register
  assign tick_d = pre_wrap & cnt_zero & ~cfg_err_o & ~restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_o <= 1'b0;
    else        tick_o <= tick_d;
  end

  // Mid-bit sampling strobes
  assign mid_hit = (cnt == (n_cur >> 1)) & ~cfg_err_o & ~restart;
  assign cap0    = mid_hit & (phase == pre_half - 1'b1);
  assign cap1    = mid_hit & (phase == pre_half);
  assign cap2    = mid_hit & (phase == pre_half + 1'b1);

  baud_rx_vote i_vote (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_i       (rx_i),
    .cap_first  (cap0),
    .cap_second (cap1),
    .cap_third  (cap2),
    .bit_o      (rx_bit_o),
    .valid_o    (rx_valid_o)
  );

endmodule

// File: rtl/baud_rate_gen_chk.sv
module baud_rate_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic div_we,
  input logic sync_i,
  input logic tick_o,
  input logic cfg_err_o,
  input logic rx_valid_o
);

  // R8: tick is a single-cycle pulse
  p_tick_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

  // R6: a divisor write is never followed by a tick on the next cycle
  p_write_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    div_we |=> !tick_o);

  // R7: a persisting error blocks ticks
  p_err_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err_o && $past(cfg_err_o)) |-> !tick_o);

  // R7: asynchronous settings are always legal
  p_async_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_i |-> !cfg_err_o);

  // R9: voted-bit strobe lasts one cycle
  p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

endmodule

bind baud_rate_gen baud_rate_gen_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .div_we     (div_we),
  .sync_i     (sync_i),
  .tick_o     (tick_o),
  .cfg_err_o  (cfg_err_o),
  .rx_valid_o (rx_valid_o)
);

// File: tb/test_baud_rate_gen.sv
`timescale 1ns/1ps
module test_baud_rate_gen;

  logic        clk;
  logic        rst_n;
  logic [15:0] div_wdata;
  logic        div_we;
  logic        wide_i, fast_i, sync_i, rx_i;
  logic        tick_o, cfg_err_o, rx_bit_o, rx_valid_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  baud_rate_gen i_baud_rate_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_wdata  (div_wdata),
    .div_we     (div_we),
    .wide_i     (wide_i),
    .fast_i     (fast_i),
    .sync_i     (sync_i),
    .rx_i       (rx_i),
    .tick_o     (tick_o),
    .cfg_err_o  (cfg_err_o),
    .rx_bit_o   (rx_bit_o),
    .rx_valid_o (rx_valid_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic        s;
    logic        w;
    logic        f;
    logic [15:0] div;
    int          per;
    logic        err;
    int          req;
  } vec_t;

  // {sync, wide, fast, divisor, expected period, expected error, requirement}
  localparam vec_t VECS [12] = '{
    '{1'b0, 1'b0, 1'b0, 16'h0002,  192, 1'b0, 2},  // R2
    '{1'b0, 1'b0, 1'b0, 16'h0102,  192, 1'b0, 2},  // R2 high byte ignored
    '{1'b0, 1'b0, 1'b1, 16'h0003,   64, 1'b0, 3},  // R3 speed bit
    '{1'b0, 1'b1, 1'b0, 16'h0102, 4144, 1'b0, 3},  // R3 wide counter
    '{1'b0, 1'b1, 1'b1, 16'h0005,   24, 1'b0, 4},  // R4
    '{1'b0, 1'b1, 1'b1, 16'h0000,    4, 1'b0, 4},  // R4 zero divisor legal
    '{1'b1, 1'b0, 1'b0, 16'h0002,   12, 1'b0, 5},  // R5
    '{1'b1, 1'b0, 1'b1, 16'h0007,   32, 1'b0, 5},  // R5 speed ignored
    '{1'b1, 1'b1, 1'b1, 16'h0100, 1028, 1'b0, 5},  // R5 wide
    '{1'b1, 1'b1, 1'b0, 16'h0001,    0, 1'b1, 7},  // R7 n=1
    '{1'b1, 1'b0, 1'b0, 16'h0300,    0, 1'b1, 7},  // R7 low byte 0
    '{1'b0, 1'b0, 1'b0, 16'h0000,   64, 1'b0, 2}   // R2 n=0 async
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts rising edges until tick_o is seen high at a falling edge
  task automatic wait_tick(input int limit, output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!tick_o && n < limit);
  endtask

  task automatic write_div(input logic s, input logic w, input logic f,
                           input logic [15:0] d);
    @(negedge clk);
    sync_i = s; wide_i = w; fast_i = f;
    div_wdata = d; div_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    div_we = 1'b0;
  endtask

  task automatic vote_case(input logic v0, input logic v1, input logic v2,
                           input logic bg);
    logic exp_bit;
    exp_bit = (v0 & v1) | (v0 & v2) | (v1 & v2);
    @(negedge clk);
    rx_i = bg; sync_i = 1'b0; wide_i = 1'b0; fast_i = 1'b1;
    div_wdata = 16'h0000; div_we = 1'b1;
    @(posedge clk);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      div_we = 1'b0;
      if (k == 9)  check(rx_valid_o == 1'b0, "R9 early valid", rx_valid_o, 0);
      if (k == 10) begin
        check(rx_valid_o == 1'b1, "R9 valid strobe", rx_valid_o, 1);
        check(rx_bit_o == exp_bit, "R9 voted bit", rx_bit_o, exp_bit);
      end
      rx_i = (k == 7) ? v0 : (k == 8) ? v1 : (k == 9) ? v2 : bg;
      if (k < 11) @(posedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int ticks;
    rst_n = 1'b0; div_wdata = '0; div_we = 1'b0;
    wide_i = 1'b0; fast_i = 1'b0; sync_i = 1'b0; rx_i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(tick_o == 1'b0 && cfg_err_o == 1'b0, "R1 reset outputs", {tick_o, cfg_err_o}, 0);
    rst_n = 1'b1;

    // R1: default 64-clock period from reset
    wait_tick(1000, n);
    check(n == 64, "R1 first tick after reset", n, 64);
    wait_tick(1000, n);
    check(n == 64, "R1 default period", n, 64);

    // Table walk: R2..R5 and R7, each also exercising restart (R6)
    for (int i = 0; i < 12; i++) begin
      write_div(VECS[i].s, VECS[i].w, VECS[i].f, VECS[i].div);
      check(cfg_err_o == VECS[i].err, $sformatf("R7 error flag vec %0d", i),
            cfg_err_o, VECS[i].err);
      if (VECS[i].err) begin
        ticks = 0;
        for (int c = 0; c < 300; c++) begin
          @(negedge clk);
          if (tick_o) ticks++;
        end
        check(ticks == 0, $sformatf("R7 ticks suppressed vec %0d", i), ticks, 0);
      end else begin
        // first tick counts from the write edge (R6)
        wait_tick(VECS[i].per + 10, n);
        check(n == VECS[i].per - 1 + 1, $sformatf("R6 restart latency R%0d vec %0d", VECS[i].req, i),
              n, VECS[i].per);
        wait_tick(VECS[i].per + 10, n);
        check(n == VECS[i].per, $sformatf("R%0d period vec %0d", VECS[i].req, i),
              n, VECS[i].per);
      end
    end

    // R6: write in the middle of a long period
    write_div(1'b0, 1'b1, 1'b0, 16'h0102);
    repeat (100) @(negedge clk);
    write_div(1'b0, 1'b1, 1'b0, 16'h0002);
    wait_tick(5000, n);
    check(n == 48, "R6 mid-period rewrite", n, 48);

    // R10: mode change alone restarts
    write_div(1'b0, 1'b0, 1'b1, 16'h0003);
    repeat (20) @(negedge clk);
    fast_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    wait_tick(1000, n);
    check(n == 256, "R10 restart on mode change", n, 256);

    // R8: tick lasts one cycle
    write_div(1'b0, 1'b1, 1'b1, 16'h0000);
    wait_tick(100, n);
    @(negedge clk);
    check(tick_o == 1'b0, "R8 single-cycle tick", tick_o, 0);

    // R9: majority filter
    vote_case(1'b1, 1'b0, 1'b1, 1'b0);
    vote_case(1'b0, 1'b0, 1'b1, 1'b1);
    vote_case(1'b1, 1'b1, 1'b0, 1'b0);
    vote_case(1'b0, 1'b1, 1'b0, 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule